// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the address of each beat in a short burst. When a qualified address strobe is accepted, it takes in the whole address. The low bits become the start offset of the burst, and the upper bits are held in a register for the length of the burst. On every later clock edge where the active-low advance input is asserted, the offset moves to the next beat of a fixed-length sequence. When the sequence has covered every beat, it wraps back to the start offset. When advance is deasserted, the burst pauses and the current address is presented again.

A static order input selects one of two orderings. The first is plain wraparound counting upward from the start offset. The second is an interleaved order, where each beat is the start offset XOR-ed with the count of beats taken so far. The output address is registered: it shows the new value in the cycle after the edge that caused the change. Arbitration between strobes and the memory access itself are handled by neighbouring logic.

Top module: `sbs_burst_seq`

## Requirements
- R1: While `rst` is high, on each rising clock edge `addr_o` and `offset_o` are cleared to zero.
- R2: When `load_i` is high at a rising edge, from the next cycle on `addr_o` equals the `addr_i` sampled at that edge. `offset_o` equals its low `OFFS_W` bits, which are the start offset.
- R3: With `order_i` low (linear), each edge with `load_i` low and `adv_n_i` low sets `offset_o` to its previous value plus one, modulo 2^`OFFS_W`. For example, start 3 gives 3, 0, 1, 2.
- R4: With `order_i` high (interleaved), after k advances since the load, `offset_o` equals the start offset XOR k. For example, start 2 gives 2, 3, 0, 1.
- R5: An edge with `load_i` low and `adv_n_i` high leaves `offset_o` unchanged (burst suspended).
- R6: After 2^`OFFS_W` advances since the last load, `offset_o` is back at the start offset, in either order.
- R7: When `load_i` and an asserted `adv_n_i` (low) occur at the same edge, the load wins. The offset becomes the new start value and does not advance.
- R8: The upper `ADDR_W-OFFS_W` bits of `addr_o` change only on a load. `addr_i` is ignored while `load_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Accepted address strobe: capture `addr_i` and restart the burst |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| order_i | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External address; the low OFFS_W bits are the start offset |
| addr_o | output | ADDR_W | Current burst address (registered) |
| offset_o | output | OFFS_W | Current beat offset, equal to the low bits of `addr_o` |

## Verification
The bench builds the block with `ADDR_W` = 16 and `OFFS_W` = 2. With a four-beat burst, every start offset can be run through both orders, including complete wraps. The bench also reaches suspends placed at each beat position, and reloads that coincide with an advance. Random runs then mix loads, advances and pauses. These runs show that the 14 upper bits ignore a moving `addr_i` between loads.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/sbs_beat_ctr.sv
// Holds the start offset and the number of beats taken; presents next-state values.
module sbs_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] start,
  output logic [W-1:0] base_d,
  output logic [W-1:0] beat_d
);
  logic [W-1:0] base_q;
  logic [W-1:0] beat_q;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    if (load) begin
      base_d = start;
      beat_d = '0;
    end else if (step) begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/sbs_order_map.sv
// Maps (start, beat count) to an offset in the selected order.
module sbs_order_map
  import sbs_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] beat,
  input  order_e       order,
  output logic [W-1:0] offs
);
  logic [W-1:0] lin;
  logic [W-1:0] ilv;

  assign lin = base + beat;

  for (genvar b = 0; b < W; b++) begin : g_ilv
    assign ilv[b] = base[b] ^ beat[b];
  end

  assign offs = (order == ORD_INTERLEAVE) ? ilv : lin;
endmodule

// File: rtl/sbs_upper_reg.sv
// Upper address bits, captured only on a load.
module sbs_upper_reg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFFS_W-1:0] offset_o
);
  localparam int UP_W = ADDR_W - OFFS_W;

  logic [OFFS_W-1:0] base_d;
  logic [OFFS_W-1:0] beat_d;
  logic [OFFS_W-1:0] offs_d;
  logic [OFFS_W-1:0] offs_q;
  logic [UP_W-1:0]   upper_q;
  order_e            order;

  assign order = order_e'(order_i);

  sbs_beat_ctr #(.W(OFFS_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load   (load_i),
    .step   (~adv_n_i),
    .start  (addr_i[OFFS_W-1:0]),
    .base_d (base_d),
    .beat_d (beat_d)
  );

  sbs_order_map #(.W(OFFS_W)) u_map (
    .base  (base_d),
    .beat  (beat_d),
    .order (order),
    .offs  (offs_d)
  );

  sbs_upper_reg #(.W(UP_W)) u_upper (
    .clk  (clk),
    .rst  (rst),
    .load (load_i),
    .d    (addr_i[ADDR_W-1:OFFS_W]),
    .q    (upper_q)
  );

  always_ff @(posedge clk) begin
    if (rst) offs_q <= '0;
    else     offs_q <= offs_d;
  end

  assign offset_o = offs_q;
  assign addr_o   = {upper_q, offs_q};
endmodule

// File: rtl/sbs_burst_seq_chk.sv
module sbs_burst_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              adv_n_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [OFFS_W-1:0] offset_o
);
  // Observer for the wrap check: start offset and advances since the load.
  logic              seen_q;
  logic [OFFS_W-1:0] start_q;
  logic [OFFS_W-1:0] steps_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      start_q <= '0;
      steps_q <= '0;
    end else if (load_i) begin
      seen_q  <= 1'b1;
      start_q <= addr_i[OFFS_W-1:0];
      steps_q <= '0;
    end else if (!adv_n_i) begin
      steps_q <= steps_q + 1'b1;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && offset_o == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(addr_i));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && !order_i) |=> offset_o == OFFS_W'($past(offset_o) + 1'b1));

  p_ilv_lsb_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && order_i) |=> offset_o[0] != $past(offset_o[0]));

  p_suspend_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> $stable(offset_o));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && steps_q == '0) |-> offset_o == start_q);

  p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (load_i && !adv_n_i) |=> offset_o == $past(addr_i[OFFS_W-1:0]));

  p_upper_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(addr_o[ADDR_W-1:OFFS_W]));

  p_offset_matches_addr: assert property (@(posedge clk) disable iff (rst)
    offset_o == addr_o[OFFS_W-1:0]);
endmodule

bind sbs_burst_seq sbs_burst_seq_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_i   (load_i),
  .adv_n_i  (adv_n_i),
  .order_i  (order_i),
  .addr_i   (addr_i),
  .addr_o   (addr_o),
  .offset_o (offset_o)
);

// File: tb/test_sbs_burst_seq.sv
`timescale 1ns/1ps
module test_sbs_burst_seq;
  localparam int ADDR_W = 16;
  localparam int OFFS_W = 2;
  localparam int N      = 1 << OFFS_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              load_i;
  logic              adv_n_i;
  logic              order_i;
  logic [ADDR_W-1:0] addr_i;
  logic [ADDR_W-1:0] addr_o;
  logic [OFFS_W-1:0] offset_o;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  int seq[$];
  int idx   = 0;
  int upper = 0;

  always #2 clk = ~clk;

  sbs_burst_seq #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_sbs_burst_seq (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .offset_o(offset_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build_seq(int s, bit ilv);
    int v;
    seq.delete();
    v = s;
    for (int i = 0; i < N; i++) begin
      if (ilv) seq.push_back(s ^ i);
      else begin
        seq.push_back(v);
        v = (v == N - 1) ? 0 : v + 1;
      end
    end
  endtask

  // Drive at a falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic cyc(bit ld, bit adv_n, int a, bit ord, string tag);
    int exp_addr;
    load_i  = ld;
    adv_n_i = adv_n;
    addr_i  = a[ADDR_W-1:0];
    order_i = ord;
    @(posedge clk);
    if (ld) begin
      upper = (a >> OFFS_W) & ((1 << (ADDR_W - OFFS_W)) - 1);
      build_seq(a & (N - 1), ord);
      idx = 0;
    end else if (!adv_n) begin
      idx = (idx + 1) % N;
    end
    @(negedge clk);
    exp_addr = (upper << OFFS_W) | seq[idx];
    check(tag, int'(offset_o), seq[idx]);
    check(tag, int'(addr_o), exp_addr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    rst = 1'b1; load_i = 1'b0; adv_n_i = 1'b1; order_i = 1'b1; addr_i = '0;
    seq.push_back(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(addr_o), 0);
    check("R1", int'(offset_o), 0);
    rst = 1'b0;

    // R2 / R3 / R6: linear from start 3 gives 3,0,1,2,3
    cyc(1, 1, 16'hABC7, 0, "R2");
    for (int i = 0; i < N; i++) cyc(0, 0, 16'h0000, 0, "R3");
    check("R6", int'(offset_o), 3);
    // R5: suspend mid-burst
    cyc(0, 0, 16'h1234, 0, "R3");
    cyc(0, 1, 16'hFFFF, 0, "R5");
    cyc(0, 1, 16'h5555, 0, "R5");
    cyc(0, 0, 16'h0000, 0, "R3");

    // R4 / R6: interleaved from every start, one full wrap plus one step
    for (int s = 0; s < N; s++) begin
      cyc(1, 1, 16'h4440 | s, 1, "R2");
      for (int i = 0; i < N; i++) begin
        cyc(0, 0, 16'h0000, 1, "R4");
        if (i == 1) cyc(0, 1, 16'h0000, 1, "R5");
      end
      check("R6", int'(offset_o), s);
      cyc(0, 0, 16'h0000, 1, "R4");
    end
    // Fixed example: interleaved start 2 gives 2,3,0,1
    cyc(1, 1, 16'h0002, 1, "R4");
    check("R4", int'(offset_o), 2);
    cyc(0, 0, 0, 1, "R4"); check("R4", int'(offset_o), 3);
    cyc(0, 0, 0, 1, "R4"); check("R4", int'(offset_o), 0);
    cyc(0, 0, 0, 1, "R4"); check("R4", int'(offset_o), 1);

    // R7: load together with advance
    cyc(0, 0, 0, 1, "R4");
    cyc(1, 0, 16'h9991, 0, "R7");
    check("R7", int'(offset_o), 1);
    cyc(0, 0, 0, 0, "R3");
    cyc(1, 0, 16'h7772, 1, "R7");
    check("R7", int'(offset_o), 2);

    // R8: addr_i moves without a load
    for (int i = 0; i < 8; i++) cyc(0, i % 2, $urandom & 16'hFFFF, 1, "R8");
    check("R8", int'(addr_o[ADDR_W-1:OFFS_W]), 16'h7772 >> OFFS_W);

    // Mixed random traffic; order changes only together with a load
    begin
      bit ord = 1'b0;
      for (int i = 0; i < 400; i++) begin
        bit ld = ($urandom % 6) == 0;
        bit an = ($urandom % 3) == 0;
        if (ld) ord = $urandom % 2;
        cyc(ld, an, $urandom & 16'hFFFF, ord, ld ? "R2" : (an ? "R5" : (ord ? "R4" : "R3")));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule